// File: doc/BRIEF.md
# Dual-Sided Interprocessor Messaging Unit

This block lets two processors that share one clock pass 32-bit words and data-less doorbell interrupts to each other. Each processor has its own register bank on a simple word-addressed bus port with separate write and read strobes. The two banks mirror each other. On each side there are four outgoing message registers, four incoming message registers, a status word and a control word. A word placed in outgoing slot n on one side can be read from incoming slot n on the opposite side.

Each channel carries three handshake flags. The sender-side flag means "slot free". The receiver-side flag means "message waiting". A third flag means "doorbell pending". Per-channel enable bits in the control word decide which flags reach that side's single level interrupt line. A doorbell is rung by setting a one-shot request bit in the control word. The request raises the pending flag on the far side and then clears itself. Software acknowledges a doorbell by writing one to the pending bit.

Within each 4-bit field of the status and control words, channel 0 takes the most significant bit and channel 3 the least.

Top module: `ipc_msg_unit`

## Requirements
- R1: After reset every slot-free flag is 1, every message-waiting and doorbell-pending flag is 0, the control word reads 0, and both interrupt lines are low.
- R2: Word offsets are: outgoing slot n at 4*n, incoming slot n at 0x10+4*n, status at 0x20, control at 0x24. Reading an outgoing slot returns the last word written there, without side effects.
- R3: A write to outgoing slot n on one side is readable from incoming slot n on the other side in the next cycle. From that cycle on, the writer's slot-free n reads 0 and the reader's message-waiting n reads 1. Both directions behave the same.
- R4: A read of incoming slot n clears the reader's message-waiting n and sets the writer's slot-free n, both in the next cycle. The message word itself is left unchanged.
- R5: The status word holds doorbell-pending n at bit 31-n, message-waiting n at bit 27-n and slot-free n at bit 23-n. All other bits read 0.
- R6: The control word holds the doorbell enable for channel n at bit 31-n, the message-waiting enable at bit 27-n, the slot-free enable at bit 23-n and the doorbell request at bit 19-n. Bits 15:0 read 0 and are ignored on write.
- R7: Writing 1 to doorbell request n makes the request read 1 for one cycle. In the following cycle the far side's doorbell-pending n reads 1 and the request reads 0. No message word or message flag changes.
- R8: Writing 1 to status bit 31-n clears doorbell-pending n. Zeros in those bits, and any value in the other status bits, change nothing.
- R9: A side's interrupt is high in exactly the cycles where one of its status flags and the matching control enable are both 1.
- R10: When one side writes slot n in the same cycle that the other side reads incoming slot n, message-waiting n stays 1 and slot-free n stays 0. A doorbell arriving in the same cycle as a write-one clear of that pending bit leaves the bit set.
- R11: Reads at unaligned offsets, at offsets above 0x24, or while the read strobe is low return 0. Writes to those offsets, and writes to the incoming slots, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe |
| a_addr | input | ADDR_W | Side A byte offset |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid in the strobe cycle |
| a_irq | output | 1 | Side A level interrupt |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_addr | input | ADDR_W | Side B byte offset |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid in the strobe cycle |
| b_irq | output | 1 | Side B level interrupt |

## Verification
The hardest cases to reach are the same-cycle collisions. In one, a message write on one side meets the read of that slot on the other side. In the other, a doorbell arrives in the same cycle software clears the pending bit. Both need the two bus ports driven in one cycle, with the request bit timed one cycle ahead of the clear. The stimulus drives both ports from a single per-cycle call, so the bench can place a write on side A and a read on side B in the same cycle. It can also ring a doorbell one cycle before the write-one clear on the far side. A behavioural model checks every cycle's read data and both interrupt lines, including the cycles where no read is issued.

// File: rtl/ipcmu_pkg.sv
// Package: shared constants and field helpers for the messaging unit.
// Assumes four channels and 32-bit register words; channel n of a field
// sits at bit base+(NUM_CH-1-n).
package ipcmu_pkg;
    localparam int NUM_CH   = 4;
    localparam int WORD_W   = 32;
    localparam int PEND_LO  = 28;  // doorbell pending / doorbell enable
    localparam int FULL_LO  = 24;  // message waiting / its enable
    localparam int FREE_LO  = 20;  // slot free / its enable
    localparam int RING_LO  = 16;  // doorbell request

    // Pull a reversed per-channel field out of a word.
    function automatic logic [NUM_CH-1:0] get_field(input logic [WORD_W-1:0] w, input int lo);
        logic [NUM_CH-1:0] f;
        for (int n = 0; n < NUM_CH; n++) f[n] = w[lo + NUM_CH - 1 - n];
        return f;
    endfunction

    // Place a per-channel field into a word in reversed order.
    function automatic logic [WORD_W-1:0] put_field(input logic [NUM_CH-1:0] f, input int lo);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int n = 0; n < NUM_CH; n++) w[lo + NUM_CH - 1 - n] = f[n];
        return w;
    endfunction
endpackage

// File: rtl/ipcmu_decode.sv
// Module: address decoder for one bank. Produces one-hot-or-zero hits for
// outgoing slots, incoming slots, status and control. Assumes word-aligned
// offsets; any offset with nonzero low bits decodes to nothing.
module ipcmu_decode
    import ipcmu_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] tx_hit,
    output logic [NUM_CH-1:0] rx_hit,
    output logic              st_hit,
    output logic              cr_hit
);
    localparam int WRD_W = ADDR_W - 2;

    logic             aligned;
    logic [WRD_W-1:0] word;

    assign aligned = (addr[1:0] == 2'b00);
    assign word    = addr[ADDR_W-1:2];

    // Compare the word index against each mapped location.
    always_comb begin
        for (int n = 0; n < NUM_CH; n++) begin
            tx_hit[n] = aligned && (word == WRD_W'(n));
            rx_hit[n] = aligned && (word == WRD_W'(NUM_CH + n));
        end
        st_hit = aligned && (word == WRD_W'(2 * NUM_CH));
        cr_hit = aligned && (word == WRD_W'(2 * NUM_CH + 1));
    end
endmodule

// File: rtl/ipcmu_side.sv
// Module: one processor-facing bank. Holds the outgoing words, the three
// flag sets, the control word and the read mux. It exchanges strobes
// and the outgoing words with its peer bank. Assumes both banks share clk.
module ipcmu_side
    import ipcmu_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [WORD_W-1:0]        wdata,
    output logic [WORD_W-1:0]        rdata,
    output logic                     irq,
    input  logic [NUM_CH-1:0]        peer_tx_wr,
    input  logic [NUM_CH-1:0]        peer_rx_rd,
    input  logic [NUM_CH-1:0]        peer_ring,
    input  logic [NUM_CH*WORD_W-1:0] peer_tx_data,
    output logic [NUM_CH-1:0]        tx_wr,
    output logic [NUM_CH-1:0]        rx_rd,
    output logic [NUM_CH-1:0]        ring,
    output logic [NUM_CH*WORD_W-1:0] tx_data
);
    logic [NUM_CH-1:0] tx_hit, rx_hit;
    logic              st_hit, cr_hit, st_wr, cr_wr;
    logic [NUM_CH-1:0] free_f, full_f, pend_f;
    logic [NUM_CH-1:0] pend_en, full_en, free_en;
    logic [WORD_W-1:0] status_w, ctrl_w;

    ipcmu_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (addr),
        .tx_hit (tx_hit),
        .rx_hit (rx_hit),
        .st_hit (st_hit),
        .cr_hit (cr_hit)
    );

    assign tx_wr = tx_hit & {NUM_CH{wr_en}};
    assign rx_rd = rx_hit & {NUM_CH{rd_en}};
    assign st_wr = st_hit & wr_en;
    assign cr_wr = cr_hit & wr_en;

    // Outgoing message words, one register per channel.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)        tx_data[n*WORD_W +: WORD_W] <= '0;
            else if (tx_wr[n]) tx_data[n*WORD_W +: WORD_W] <= wdata;
        end
    end

    // Handshake flags: a local write or peer read moves slot-free, a peer write
    // or local read moves message-waiting, and a peer doorbell or W1C moves pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_f <= '1;
            full_f <= '0;
            pend_f <= '0;
        end else begin
            free_f <= (free_f | peer_rx_rd) & ~tx_wr;
            full_f <= (full_f & ~rx_rd) | peer_tx_wr;
            pend_f <= (pend_f & ~(get_field(wdata, PEND_LO) & {NUM_CH{st_wr}})) | peer_ring;
        end
    end

    // Control word enables and the one-shot doorbell request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_en <= '0;
            full_en <= '0;
            free_en <= '0;
            ring    <= '0;
        end else begin
            if (cr_wr) begin
                pend_en <= get_field(wdata, PEND_LO);
                full_en <= get_field(wdata, FULL_LO);
                free_en <= get_field(wdata, FREE_LO);
            end
            ring <= cr_wr ? get_field(wdata, RING_LO) : '0;
        end
    end

    assign status_w = put_field(pend_f, PEND_LO) | put_field(full_f, FULL_LO)
                    | put_field(free_f, FREE_LO);
    assign ctrl_w   = put_field(pend_en, PEND_LO) | put_field(full_en, FULL_LO)
                    | put_field(free_en, FREE_LO) | put_field(ring, RING_LO);

    // Read mux; zero when no read or no mapped location is hit.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (tx_hit[n]) rdata = tx_data[n*WORD_W +: WORD_W];
                if (rx_hit[n]) rdata = peer_tx_data[n*WORD_W +: WORD_W];
            end
            if (st_hit) rdata = status_w;
            if (cr_hit) rdata = ctrl_w;
        end
    end

    // Level interrupt: any flag together with its enable.
    assign irq = |((pend_f & pend_en) | (full_f & full_en) | (free_f & free_en));
endmodule

// File: rtl/ipc_msg_unit.sv
// Module: top of the messaging unit. Instantiates the two mirrored banks
// and cross-wires strobes, doorbells and message words between them.
// Assumes one shared clock and a synchronous active-low reset.
module ipc_msg_unit
    import ipcmu_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr_en,
    input  logic              a_rd_en,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [31:0]       a_wdata,
    output logic [31:0]       a_rdata,
    output logic              a_irq,
    input  logic              b_wr_en,
    input  logic              b_rd_en,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [31:0]       b_wdata,
    output logic [31:0]       b_rdata,
    output logic              b_irq
);
    localparam int SIDES = 2;

    logic                     wr_en [SIDES];
    logic                     rd_en [SIDES];
    logic [ADDR_W-1:0]        addr  [SIDES];
    logic [WORD_W-1:0]        wdata [SIDES];
    logic [WORD_W-1:0]        rdata [SIDES];
    logic                     irq   [SIDES];
    logic [NUM_CH-1:0]        tx_wr [SIDES];
    logic [NUM_CH-1:0]        rx_rd [SIDES];
    logic [NUM_CH-1:0]        ring  [SIDES];
    logic [NUM_CH*WORD_W-1:0] txd   [SIDES];

    assign wr_en[0] = a_wr_en;  assign wr_en[1] = b_wr_en;
    assign rd_en[0] = a_rd_en;  assign rd_en[1] = b_rd_en;
    assign addr[0]  = a_addr;   assign addr[1]  = b_addr;
    assign wdata[0] = a_wdata;  assign wdata[1] = b_wdata;
    assign a_rdata  = rdata[0]; assign b_rdata  = rdata[1];
    assign a_irq    = irq[0];   assign b_irq    = irq[1];

    // Two identical banks, each wired to the other as its peer.
    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int P = SIDES - 1 - s;
        ipcmu_side #(.ADDR_W(ADDR_W)) u_side (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (wr_en[s]),
            .rd_en        (rd_en[s]),
            .addr         (addr[s]),
            .wdata        (wdata[s]),
            .rdata        (rdata[s]),
            .irq          (irq[s]),
            .peer_tx_wr   (tx_wr[P]),
            .peer_rx_rd   (rx_rd[P]),
            .peer_ring    (ring[P]),
            .peer_tx_data (txd[P]),
            .tx_wr        (tx_wr[s]),
            .rx_rd        (rx_rd[s]),
            .ring         (ring[s]),
            .tx_data      (txd[s])
        );
    end
endmodule

// File: rtl/ipcmu_chk.sv
// Module: port-level property checker for the messaging unit, bound to the top.
module ipcmu_chk
    import ipcmu_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_wr_en,
    input logic              a_rd_en,
    input logic [ADDR_W-1:0] a_addr,
    input logic [31:0]       a_wdata,
    input logic [31:0]       a_rdata,
    input logic              a_irq,
    input logic              b_wr_en,
    input logic              b_rd_en,
    input logic [ADDR_W-1:0] b_addr,
    input logic [31:0]       b_wdata,
    input logic [31:0]       b_rdata,
    input logic              b_irq
);
    localparam logic [ADDR_W-1:0] TX0 = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] RX0 = ADDR_W'(4 * NUM_CH);
    localparam logic [ADDR_W-1:0] STA = ADDR_W'(8 * NUM_CH);
    localparam logic [ADDR_W-1:0] CTL = ADDR_W'(8 * NUM_CH + 4);

    a_r1_irq_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!a_irq && !b_irq));

    a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_rd_en |-> a_rdata == '0) and (!b_rd_en |-> b_rdata == '0));

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd_en && (a_addr[1:0] != 2'b00 || a_addr > CTL)) |-> a_rdata == '0);

    a_r3_a_to_b_word: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_en && a_addr == TX0) ##1 (b_rd_en && b_addr == RX0) |-> b_rdata == $past(a_wdata));

    a_r3_b_to_a_word: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr_en && b_addr == TX0) ##1 (a_rd_en && a_addr == RX0) |-> a_rdata == $past(b_wdata));

    a_r7_doorbell_arrives: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_en && a_addr == CTL && a_wdata[19]) ##2 (b_rd_en && b_addr == STA) |-> b_rdata[31]);
endmodule

bind ipc_msg_unit ipcmu_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ipc_msg_unit_test.sv
module ipc_msg_unit_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        a_wr_en = 0, a_rd_en = 0, b_wr_en = 0, b_rd_en = 0;
    logic [5:0]  a_addr = 0, b_addr = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int checks = 0, failures = 0;
    bit done = 0;

    // Reference state per side (0 = A, 1 = B)
    bit [31:0] m_tx   [2][4];
    bit [3:0]  m_free [2], m_full [2], m_pend [2];
    bit [3:0]  m_epd  [2], m_efl [2], m_efr [2], m_ring [2];

    always #5 clk = ~clk;

    ipc_msg_unit uut (
        .clk(clk), .rst_n(rst_n),
        .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 2; s++) begin
            for (int n = 0; n < 4; n++) m_tx[s][n] = 0;
            m_free[s] = 4'hF; m_full[s] = 0; m_pend[s] = 0;
            m_epd[s] = 0; m_efl[s] = 0; m_efr[s] = 0; m_ring[s] = 0;
        end
    endtask

    function automatic bit [31:0] m_read(int s, bit rd, bit [5:0] a);
        bit [31:0] v = 0;
        if (!rd) return 0;
        for (int n = 0; n < 4; n++) begin
            if (a == 6'(4 * n))      v = m_tx[s][n];
            if (a == 6'(16 + 4 * n)) v = m_tx[1 - s][n];
            if (a == 6'h20) begin
                v[31 - n] = m_pend[s][n]; v[27 - n] = m_full[s][n]; v[23 - n] = m_free[s][n];
            end
            if (a == 6'h24) begin
                v[31 - n] = m_epd[s][n]; v[27 - n] = m_efl[s][n];
                v[23 - n] = m_efr[s][n]; v[19 - n] = m_ring[s][n];
            end
        end
        return v;
    endfunction

    function automatic bit m_irq(int s);
        return |((m_pend[s] & m_epd[s]) | (m_full[s] & m_efl[s]) | (m_free[s] & m_efr[s]));
    endfunction

    // One clock: drive both ports, compare before the edge, advance the model.
    task automatic go(input bit aw, input bit ar, input bit [5:0] aa, input bit [31:0] ad,
                      input bit bw, input bit br, input bit [5:0] ba, input bit [31:0] bd,
                      input string tag);
        bit w [2]; bit r [2]; bit [5:0] ad2 [2]; bit [31:0] wd [2];
        bit [3:0] nfree [2], nfull [2], npend [2], nring [2];
        a_wr_en = aw; a_rd_en = ar; a_addr = aa; a_wdata = ad;
        b_wr_en = bw; b_rd_en = br; b_addr = ba; b_wdata = bd;
        w[0] = aw; r[0] = ar; ad2[0] = aa; wd[0] = ad;
        w[1] = bw; r[1] = br; ad2[1] = ba; wd[1] = bd;
        #3;
        check(a_rdata == m_read(0, ar, aa), tag, "A rdata", a_rdata, m_read(0, ar, aa));
        check(b_rdata == m_read(1, br, ba), tag, "B rdata", b_rdata, m_read(1, br, ba));
        check(a_irq == m_irq(0), "R9", "A irq", 32'(a_irq), 32'(m_irq(0)));
        check(b_irq == m_irq(1), "R9", "B irq", 32'(b_irq), 32'(m_irq(1)));
        for (int s = 0; s < 2; s++) begin
            int p = 1 - s;
            for (int n = 0; n < 4; n++) begin
                bit txw_s = w[s] && ad2[s] == 6'(4 * n);
                bit txw_p = w[p] && ad2[p] == 6'(4 * n);
                bit rxr_s = r[s] && ad2[s] == 6'(16 + 4 * n);
                bit rxr_p = r[p] && ad2[p] == 6'(16 + 4 * n);
                nfree[s][n] = txw_s ? 1'b0 : (rxr_p ? 1'b1 : m_free[s][n]);
                nfull[s][n] = txw_p ? 1'b1 : (rxr_s ? 1'b0 : m_full[s][n]);
                npend[s][n] = m_ring[p][n] ? 1'b1 :
                              ((w[s] && ad2[s] == 6'h20 && wd[s][31 - n]) ? 1'b0 : m_pend[s][n]);
                nring[s][n] = (w[s] && ad2[s] == 6'h24) ? wd[s][19 - n] : 1'b0;
            end
        end
        @(posedge clk);
        for (int s = 0; s < 2; s++) begin
            for (int n = 0; n < 4; n++) begin
                if (w[s] && ad2[s] == 6'(4 * n)) m_tx[s][n] = wd[s];
                if (w[s] && ad2[s] == 6'h24) begin
                    m_epd[s][n] = wd[s][31 - n]; m_efl[s][n] = wd[s][27 - n];
                    m_efr[s][n] = wd[s][23 - n];
                end
            end
            m_free[s] = nfree[s]; m_full[s] = nfull[s];
            m_pend[s] = npend[s]; m_ring[s] = nring[s];
        end
        @(negedge clk);
    endtask

    task automatic a_op(input bit wr, input bit [5:0] a, input bit [31:0] d, input string tag);
        go(wr, !wr, a, d, 0, 0, 0, 0, tag);
    endtask
    task automatic b_op(input bit wr, input bit [5:0] a, input bit [31:0] d, input string tag);
        go(0, 0, 0, 0, wr, !wr, a, d, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state of both banks
        go(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        go(0, 1, 6'h20, 0, 0, 1, 6'h20, 0, "R1");
        go(0, 1, 6'h24, 0, 0, 1, 6'h24, 0, "R1");
        // R3 / R2: fill all four A outgoing slots
        a_op(1, 6'h00, 32'h1111_0000, "R3");
        a_op(1, 6'h04, 32'h2222_0001, "R3");
        a_op(1, 6'h08, 32'h3333_0002, "R3");
        a_op(1, 6'h0C, 32'h4444_0003, "R3");
        b_op(0, 6'h20, 0, "R5");
        a_op(0, 6'h20, 0, "R5");
        a_op(0, 6'h08, 0, "R2");
        // R4: B consumes slot 2
        b_op(0, 6'h18, 0, "R4");
        go(0, 1, 6'h20, 0, 0, 1, 6'h20, 0, "R4");
        b_op(0, 6'h18, 0, "R4");
        // R3: reverse direction
        b_op(1, 6'h04, 32'hB00B_0001, "R3");
        a_op(0, 6'h14, 0, "R3");
        a_op(0, 6'h20, 0, "R3");
        // R6 / R9: slot-free enable ch3 on A, then B reads slot 3
        a_op(1, 6'h24, 32'h0010_0000, "R6");
        a_op(0, 6'h24, 0, "R6");
        b_op(0, 6'h1C, 0, "R9");
        go(0, 0, 0, 0, 0, 0, 0, 0, "R9");
        b_op(1, 6'h24, 32'h0F00_0000, "R9");
        go(0, 0, 0, 0, 0, 0, 0, 0, "R9");
        b_op(1, 6'h24, 32'h0000_FFFF, "R6");
        b_op(0, 6'h24, 0, "R6");
        // R7: doorbell from B on channel 2
        b_op(1, 6'h24, 32'h0002_0000, "R7");
        go(0, 1, 6'h20, 0, 0, 1, 6'h24, 0, "R7");
        go(0, 1, 6'h20, 0, 0, 1, 6'h24, 0, "R7");
        b_op(0, 6'h20, 0, "R7");
        a_op(1, 6'h24, 32'h2000_0000, "R9");
        go(0, 0, 0, 0, 0, 0, 0, 0, "R9");
        // R8: write-one clear
        a_op(1, 6'h20, 32'hDFFF_FFFF, "R8");
        a_op(0, 6'h20, 0, "R8");
        a_op(1, 6'h20, 32'h2000_0000, "R8");
        a_op(0, 6'h20, 0, "R8");
        // R10: write meets peer read on slot 0
        go(1, 0, 6'h00, 32'hCAFE_F00D, 0, 1, 6'h10, 0, "R10");
        go(0, 1, 6'h20, 0, 0, 1, 6'h20, 0, "R10");
        b_op(0, 6'h10, 0, "R10");
        // R10: doorbell arrives together with the clear
        b_op(1, 6'h24, 32'h0008_0000, "R10");
        a_op(1, 6'h20, 32'h8000_0000, "R10");
        a_op(0, 6'h20, 0, "R10");
        // R11: unmapped and read-only locations
        a_op(1, 6'h28, 32'hFFFF_FFFF, "R11");
        a_op(1, 6'h01, 32'hFFFF_FFFF, "R11");
        a_op(1, 6'h10, 32'hDEAD_BEEF, "R11");
        b_op(1, 6'h3C, 32'hFFFF_FFFF, "R11");
        a_op(0, 6'h28, 0, "R11");
        a_op(0, 6'h02, 0, "R11");
        a_op(0, 6'h3C, 0, "R11");
        go(0, 1, 6'h10, 0, 0, 1, 6'h20, 0, "R11");
        go(0, 1, 6'h20, 0, 0, 1, 6'h14, 0, "R11");
        a_op(0, 6'h24, 0, "R11");
        go(0, 0, 0, 0, 0, 0, 0, 0, "R11");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule